// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Trigger

This block turns one 32-bit register write into software interrupts between CPUs. The write carries an interrupt number from 0 to 15, a target selection, and a security attribute. The CPU that issued the write is given on a separate input. The block works out which CPUs are targeted. It then sets one pending bit for each pair of target and sender, per interrupt number, and stores the security attribute beside each bit.

Each target CPU has its own acknowledge port, which clears one pending entry, chosen by interrupt number and sender. Arbitration between pending interrupts is outside this block. The whole pending array and the attribute array are brought out flat, together with one summary interrupt line per target CPU.

The write side is a valid/ready stream. Its ready output is always high, so no back-pressure is ever applied and a write is taken in every cycle that valid is high. The acknowledge ports are plain strobes.

Top module: `sgi_trigger`

## Requirements
- R1: After reset every pending bit, every attribute bit and every `irq` line is 0, and `wr_ready` is 1.
- R2: A write is taken in each cycle `wr_valid` is high. The interrupt number is `wr_data[3:0]`. Bits [14:4] and [31:26] have no effect.
- R3: When the selector `wr_data[25:24]` is 0, the targets are the CPUs whose bit is set in the list `wr_data[23:16]` (bit 16 is CPU 0).
- R4: List bits at CPU positions of `NCPU` or above are ignored.
- R5: Selector 1 targets every CPU except the writer `wr_cpu`. Selector 2 targets only the writer. In both cases the list field is ignored.
- R6: Selector 3 is reserved: the write changes no pending or attribute bit.
- R7: The pending bit of a target shows on `pend_vec` in the cycle after the write's clock edge. Entry (target t, number n, sender s) sits at bit `t*16*NCPU + n*NCPU + s`.
- R8: `wr_data[15]` is stored in `ns_vec` at the same position as the entry it sets (1 = non-secure, 0 = secure only). A repeated write to an entry that is already set leaves a single pending bit and takes the new attribute.
- R9: A strobe on `ack_valid[t]` clears the entry (t, `ack_id` slice t, `ack_src` slice t), both its pending and its attribute bit, at the next edge. Acknowledging an empty entry changes nothing.
- R10: If a write sets an entry in the same cycle that the entry is acknowledged, the entry ends up set.
- R11: `irq[t]` is 1 exactly when target t has at least one pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Trigger write present |
| wr_ready | output | 1 | Always 1; the write is never stalled |
| wr_data | input | 32 | Trigger word: number, attribute, list, selector |
| wr_cpu | input | CPU_W | Index of the writing CPU |
| ack_valid | input | NCPU | Acknowledge strobe, one per target CPU |
| ack_id | input | NCPU*4 | Interrupt number to clear, 4 bits per target |
| ack_src | input | NCPU*CPU_W | Sender of the entry to clear, per target |
| irq | output | NCPU | Any entry pending, per target |
| pend_vec | output | NCPU*16*NCPU | Pending array, layout per R7 |
| ns_vec | output | NCPU*16*NCPU | Non-secure attribute array, same layout |

## Verification
The decode is driven with every selector value from several different writers. Because of this, a mask that ignores the writer, or includes it where it should not, shows up on a specific target. List words that set bits above the implemented CPUs test the masking of the upper list bits, and words with noise in the unused fields test that only [3:0] selects the number. Repeated writes with the other attribute, acknowledges of empty entries, and an acknowledge that coincides with a set of the same entry separate merge, clear and priority behaviour.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int NUM_IDS   = 16;
  localparam int ID_W      = 4;
  localparam int LIST_LO   = 16;
  localparam int LIST_W    = 8;
  localparam int SEL_LO    = 24;
  localparam int NS_POS    = 15;

  typedef enum logic [1:0] {
    SEL_LIST   = 2'd0,
    SEL_OTHERS = 2'd1,
    SEL_SELF   = 2'd2,
    SEL_RSVD   = 2'd3
  } sel_e;

  typedef struct packed {
    logic [ID_W-1:0] num;
    logic            nsec;
  } trig_cmd_t;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [31:0]      data,
  input  logic [CPU_W-1:0] who,
  output trig_cmd_t        cmd,
  output logic [NCPU-1:0]  tmask
);
  sel_e              sel;
  logic [LIST_W-1:0] list;
  wire unused_fields = ^{data[31:26], data[14:4], list};

  assign sel      = sel_e'(data[SEL_LO +: 2]);
  assign list     = data[LIST_LO +: LIST_W];
  assign cmd.num  = data[ID_W-1:0];
  assign cmd.nsec = data[NS_POS];

  always_comb begin
    tmask = '0;
    if (fire) begin
      for (int i = 0; i < NCPU; i++) begin
        unique case (sel)
          SEL_LIST:   tmask[i] = list[i];
          SEL_OTHERS: tmask[i] = (i != int'(who));
          SEL_SELF:   tmask[i] = (i == int'(who));
          default:    tmask[i] = 1'b0;
        endcase
      end
    end
  end

  // R5: the writer never receives an all-but-sender interrupt
  assert_others_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_OTHERS && int'(who) < NCPU) |-> !tmask[who]);
  // R5: sender-only selects exactly one CPU
  assert_self_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_SELF && int'(who) < NCPU) |-> $countones(tmask) == 1);
  // R6: the reserved selector targets nobody
  assert_rsvd_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_RSVD) |-> tmask == '0);
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
  import sgi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  trig_cmd_t               set_cmd,
  input  logic [CPU_W-1:0]        set_src,
  input  logic                    ack_en,
  input  logic [ID_W-1:0]         ack_id,
  input  logic [CPU_W-1:0]        ack_src,
  output logic [NUM_IDS*NCPU-1:0] pend,
  output logic [NUM_IDS*NCPU-1:0] nsec,
  output logic                    irq
);
  localparam int ENTRIES = NUM_IDS * NCPU;

  for (genvar n = 0; n < NUM_IDS; n++) begin : g_id
    for (genvar s = 0; s < NCPU; s++) begin : g_src
      logic hit_set, hit_ack;
      assign hit_set = set_en && int'(set_cmd.num) == n && int'(set_src) == s;
      assign hit_ack = ack_en && int'(ack_id) == n && int'(ack_src) == s;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend[n*NCPU+s] <= 1'b0;
          nsec[n*NCPU+s] <= 1'b0;
        end else if (hit_set) begin
          pend[n*NCPU+s] <= 1'b1;
          nsec[n*NCPU+s] <= set_cmd.nsec;
        end else if (hit_ack) begin
          pend[n*NCPU+s] <= 1'b0;
          nsec[n*NCPU+s] <= 1'b0;
        end
      end
    end
  end

  assign irq = |pend;

  // R9: an acknowledge without a coincident set empties the entry
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && int'(ack_src) < NCPU &&
     !(set_en && set_cmd.num == ack_id && set_src == ack_src))
    |=> pend[int'($past(ack_id))*NCPU + int'($past(ack_src))] == 1'b0);
  // R10: a set always lands, even against an acknowledge of the same entry
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && int'(set_src) < NCPU)
    |=> pend[int'($past(set_cmd.num))*NCPU + int'($past(set_src))] &&
        nsec[int'($past(set_cmd.num))*NCPU + int'($past(set_src))] == $past(set_cmd.nsec));
  // R11: with nothing pending there is no request
  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);

  initial begin
    assert (ENTRIES == NUM_IDS * NCPU);
  end
endmodule

// File: rtl/sgi_trigger.sv
module sgi_trigger
  import sgi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [31:0]                    wr_data,
  input  logic [CPU_W-1:0]               wr_cpu,
  input  logic [NCPU-1:0]                ack_valid,
  input  logic [NCPU*ID_W-1:0]           ack_id,
  input  logic [NCPU*CPU_W-1:0]          ack_src,
  output logic [NCPU-1:0]                irq,
  output logic [NCPU*NUM_IDS*NCPU-1:0]   pend_vec,
  output logic [NCPU*NUM_IDS*NCPU-1:0]   ns_vec
);
  localparam int BANK_W = NUM_IDS * NCPU;

  trig_cmd_t       cmd;
  logic [NCPU-1:0] tmask;
  logic            fire;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  sgi_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(wr_data), .who(wr_cpu),
    .cmd(cmd), .tmask(tmask)
  );

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    sgi_pend_bank #(.NCPU(NCPU), .CPU_W(CPU_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (tmask[t]),
      .set_cmd (cmd),
      .set_src (wr_cpu),
      .ack_en  (ack_valid[t]),
      .ack_id  (ack_id[t*ID_W +: ID_W]),
      .ack_src (ack_src[t*CPU_W +: CPU_W]),
      .pend    (pend_vec[t*BANK_W +: BANK_W]),
      .nsec    (ns_vec[t*BANK_W +: BANK_W]),
      .irq     (irq[t])
    );
  end

  // R6: a reserved-selector write with no acknowledge leaves the arrays alone
  assert_rsvd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[SEL_LO +: 2] == 2'd3 && ack_valid == '0)
    |=> $stable(pend_vec) && $stable(ns_vec));
  // R1: the write side never stalls
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  initial begin
    assert (NCPU >= 1 && NCPU <= LIST_W);
  end
endmodule

// File: tb/sgi_trigger_test.sv
module sgi_trigger_test;
  localparam int NCPU = 4;
  localparam int CPU_W = 2;
  localparam int W = NCPU * 16 * NCPU;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [31:0] wr_data = '0;
  logic [CPU_W-1:0] wr_cpu = '0;
  logic [NCPU-1:0] ack_valid = '0;
  logic [NCPU*4-1:0] ack_id = '0;
  logic [NCPU*CPU_W-1:0] ack_src = '0;
  logic [NCPU-1:0] irq;
  logic [W-1:0] pend_vec, ns_vec;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [W-1:0] m_p = '0, m_n = '0;
  logic [W-1:0] q_p[$], q_n[$];
  logic [NCPU-1:0] q_i[$];
  string q_t[$];

  always #10 clk = ~clk;

  sgi_trigger #(.NCPU(NCPU)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_cpu(wr_cpu), .ack_valid(ack_valid), .ack_id(ack_id),
    .ack_src(ack_src), .irq(irq), .pend_vec(pend_vec), .ns_vec(ns_vec));

  function automatic logic [31:0] word(int sel, int list, bit ns, int id);
    return {6'b0, 2'(sel), 8'(list), ns, 11'b0, 4'(id)};
  endfunction

  function automatic int pos(int t, int id, int s);
    return t*16*NCPU + id*NCPU + s;
  endfunction

  task automatic check_vec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, update the model, queue expectations
  task automatic op(bit do_wr, logic [31:0] d, int cpu, bit do_ack,
                    int at, int aid, int asrc, string tag);
    @(negedge clk);
    wr_valid = do_wr; wr_data = d; wr_cpu = CPU_W'(cpu);
    ack_valid = '0; ack_id = '0; ack_src = '0;
    if (do_ack) begin
      ack_valid[at] = 1'b1;
      ack_id[at*4 +: 4] = 4'(aid);
      ack_src[at*CPU_W +: CPU_W] = CPU_W'(asrc);
      m_p[pos(at, aid, asrc)] = 1'b0;
      m_n[pos(at, aid, asrc)] = 1'b0;
    end
    if (do_wr) begin
      for (int t = 0; t < NCPU; t++) begin
        bit hit;
        case (int'(d[25:24]))
          0: hit = d[16+t];
          1: hit = (t != cpu);
          2: hit = (t == cpu);
          default: hit = 0;
        endcase
        if (hit) begin
          m_p[pos(t, int'(d[3:0]), cpu)] = 1'b1;
          m_n[pos(t, int'(d[3:0]), cpu)] = d[15];
        end
      end
    end
    @(posedge clk);
    #1;
    begin
      logic [NCPU-1:0] ei;
      for (int t = 0; t < NCPU; t++) ei[t] = |m_p[t*16*NCPU +: 16*NCPU];
      q_p.push_back(m_p); q_n.push_back(m_n); q_i.push_back(ei); q_t.push_back(tag);
    end
  endtask

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_p.size() > 0) begin
        logic [W-1:0] ep, en;
        logic [NCPU-1:0] ei;
        string tg;
        ep = q_p.pop_front(); en = q_n.pop_front(); ei = q_i.pop_front(); tg = q_t.pop_front();
        check_vec({tg, " pend"}, pend_vec, ep);
        check_vec({tg, " ns"}, ns_vec, en);
        n_checks++;
        if (irq !== ei) begin
          n_fail++;
          $display("FAIL R11 %s irq: actual %b expected %b", tg, irq, ei);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check_vec("R1 reset", pend_vec, '0);
    check_vec("R1 reset", ns_vec, '0);
    n_checks++;
    if (irq !== '0 || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 irq/ready: actual %b/%b expected 0000/1", irq, wr_ready);
    end
    op(1, word(0, 'b1010, 1, 5), 1, 0, 0, 0, 0, "R3 R7 list cpu1 id5");
    op(1, word(0, 'hF1, 0, 3), 2, 0, 0, 0, 0, "R4 upper list bits");
    op(1, word(1, 'h0, 1, 7), 0, 0, 0, 0, 0, "R5 others from cpu0");
    op(1, word(1, 'hF, 0, 9), 2, 0, 0, 0, 0, "R5 others list ignored");
    op(1, word(2, 'h0, 1, 15), 3, 0, 0, 0, 0, "R5 self cpu3");
    op(1, word(2, 'hE, 0, 0), 1, 0, 0, 0, 0, "R5 self list ignored");
    op(1, word(3, 'hF, 1, 2), 0, 0, 0, 0, 0, "R6 reserved selector");
    op(1, word(0, 'b0010, 0, 5), 1, 0, 0, 0, 0, "R8 merge new attribute");
    op(1, word(0, 'b0100, 1, 6) | 32'h0000_7FF0, 3, 0, 0, 0, 0, "R2 ignored fields");
    op(0, '0, 0, 1, 3, 5, 1, "R9 ack clears");
    op(0, '0, 0, 1, 2, 4, 2, "R9 ack empty entry");
    op(1, word(0, 'b0001, 1, 3), 2, 1, 0, 3, 2, "R10 set beats ack");
    op(1, word(3, 'b0001, 1, 3), 2, 1, 0, 3, 2, "R6 reserved with ack");
    op(0, '0, 0, 1, 3, 15, 3, "R11 target3 drain");
    op(0, '0, 0, 1, 3, 7, 0, "R11 target3 drain");
    op(0, '0, 0, 1, 3, 9, 2, "R11 target3 drain");
    op(0, '0, 0, 1, 3, 5, 1, "R11 target3 drain");
    op(0, '0, 0, 0, 0, 0, 0, "R7 idle hold");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule